// File: doc/BRIEF.md
# Three-Phase Gate Control Logic

This block is the digital core of a three-phase half-bridge gate driver. Each phase takes a high-side and a low-side command. The block turns them into gate requests for the six external switches. It makes sure the two switches of a phase never conduct together and inserts a fixed idle gap between turning one switch off and turning the other on. Each gate output is an enable plus a level. With that encoding the analog stage can tell driven-on, driven-off and released (high impedance) apart.

On top of the phase logic the block obeys several overrides: an active-low coast input, a disable-all request from the fault logic, a supply-good indication, and per-phase bootstrap status bits. The bootstrap bits give a high-side gate a hysteresis rule. Once the gate drops out, it needs a fresh command edge before it can turn on again. A separate active-low control pin is measured by pulse length. A short glitch is ignored. A moderate pulse produces a one-cycle fault-clear strobe. A long hold drives every gate low, keeps the gates driven low for a hold-off period, then releases them and enters sleep. All times are counted in clock cycles.

Top module: `tri_gate_ctrl`

## Requirements
- R1: Per phase, after the two-flop input synchronizer, high=1/low=0 turns the high-side gate on and high=0/low=1 turns the low-side gate on. Both 0 or both 1 keep both gates off. A command change reaches the gate level on the third rising edge after it is applied.
- R2: The two gates of a phase are never on at once. After any gate of a phase turns off, both stay off for at least DEAD_CYC cycles (DEAD_CYC+1 in this implementation) before either turns on.
- R3: While the synchronized coast input is low, all six gate levels are 0 with enables still 1, and no fault-clear strobe is produced.
- R4: A disable_all sampled high forces all gate levels to 0 at that same clock edge.
- R5: A control-pin low pulse shorter than FILT_CYC cycles has no effect on any output.
- R6: A control-pin low pulse of at least FILT_CYC cycles and less than SHUT_CYC cycles gives exactly one cycle of fault_clr, three edges after release, and leaves the gates unchanged.
- R7: Holding the control pin low for SHUT_CYC cycles pulses fault_clr and forces all levels to 0 while the enables stay 1. This lasts HOLD_CYC cycles. After that, sleep is asserted and every enable and level is 0 (released).
- R8: A high-side gate may start only while its boot_ok bit is 1. Once on, it stays on even if boot_ok falls.
- R9: If boot_low is 1 while a high-side gate is on, that gate turns off at the next edge. It stays off until its high command has been seen at 0 and then 1 again. Other phases are unaffected.
- R10: After leaving sleep, enables return to 1 while all levels stay 0 until supply_good is 1. Whenever supply_good is sampled low, all levels go to 0 at that edge.
- R11: Output encoding is enable=1/level=1 for on, enable=1/level=0 for driven off, and enable=0/level=0 for released. After system reset, all enables are 1 and all levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| hi_cmd | input | N_PH | High-side command per phase |
| lo_cmd | input | N_PH | Low-side command per phase |
| coast_n | input | 1 | Coast request, active low |
| pin_rst_n | input | 1 | Fault-clear / sleep control pin, active low |
| boot_ok | input | N_PH | Bootstrap above turn-on threshold |
| boot_low | input | N_PH | Bootstrap below turn-off threshold |
| disable_all | input | 1 | Disable-all request from fault logic |
| supply_good | input | 1 | Internal supply good |
| hs_en | output | N_PH | High-side gate driven |
| hs_lvl | output | N_PH | High-side gate level |
| ls_en | output | N_PH | Low-side gate driven |
| ls_lvl | output | N_PH | Low-side gate level |
| fault_clr | output | 1 | One-cycle fault-clear strobe |
| asleep | output | 1 | Sleep state indication |

## Verification
The assertions check the following on every cycle:
- no phase ever has both gates on;
- the off gap before any turn-on;
- the forced-off response to coast, disable_all and a missing supply;
- the bootstrap start and dropout rules;
- fault_clr being a single-cycle strobe;
- all outputs being released during sleep.

Only the bench scenarios can show the pulse-length decoding of the control pin, with its exact filter and shutdown boundaries and the hold-off duration. The same applies to the need for a fresh command edge after a dropout and to exact latencies through the synchronizers.

// File: rtl/tri_gate_ctrl.sv
module tri_gate_ctrl #(
  parameter int N_PH     = 3,
  parameter int DEAD_CYC = 4,
  parameter int FILT_CYC = 3,
  parameter int SHUT_CYC = 40,
  parameter int HOLD_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] hi_cmd,
  input  logic [N_PH-1:0] lo_cmd,
  input  logic            coast_n,
  input  logic            pin_rst_n,
  input  logic [N_PH-1:0] boot_ok,
  input  logic [N_PH-1:0] boot_low,
  input  logic            disable_all,
  input  logic            supply_good,
  output logic [N_PH-1:0] hs_en,
  output logic [N_PH-1:0] hs_lvl,
  output logic [N_PH-1:0] ls_en,
  output logic [N_PH-1:0] ls_lvl,
  output logic            fault_clr,
  output logic            asleep
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int LW = $clog2(SHUT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  typedef enum logic [1:0] {M_RUN, M_HOLD, M_SLEEP} mode_t;

  logic [N_PH-1:0] hi_m, hi_s, lo_m, lo_s, gh, gl;
  logic            co_m, co_s, pr_m, pr_s;
  mode_t           mode;
  logic [LW-1:0]   lowcnt;
  logic [HW-1:0]   hcnt;
  logic            run, kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_m <= '0; hi_s <= '0; lo_m <= '0; lo_s <= '0;
      co_m <= 1'b0; co_s <= 1'b0; pr_m <= 1'b1; pr_s <= 1'b1;
    end else begin
      hi_m <= hi_cmd; hi_s <= hi_m;
      lo_m <= lo_cmd; lo_s <= lo_m;
      co_m <= coast_n; co_s <= co_m;
      pr_m <= pin_rst_n; pr_s <= pr_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_RUN;
      lowcnt    <= '0;
      hcnt      <= '0;
      fault_clr <= 1'b0;
    end else begin
      fault_clr <= 1'b0;
      if (pr_s) lowcnt <= '0;
      else if (lowcnt != LW'(SHUT_CYC)) lowcnt <= lowcnt + 1'b1;
      case (mode)
        M_RUN: begin
          if (pr_s) begin
            if (lowcnt >= LW'(FILT_CYC)) fault_clr <= 1'b1;
          end else if (lowcnt == LW'(SHUT_CYC - 1)) begin
            mode      <= M_HOLD;
            hcnt      <= HW'(HOLD_CYC);
            fault_clr <= 1'b1;
          end
        end
        M_HOLD: begin
          if (hcnt <= HW'(1)) mode <= M_SLEEP;
          else hcnt <= hcnt - 1'b1;
        end
        M_SLEEP: if (pr_s) mode <= M_RUN;
        default: mode <= M_RUN;
      endcase
    end
  end

  assign run  = (mode == M_RUN);
  assign kill = ~co_s | disable_all | ~supply_good | ~run;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic          h_q, l_q, blk_q;
    logic [DW-1:0] dc_q;
    logic          drop, keep_h, start_h, want_l;

    assign drop    = h_q & boot_low[p];
    assign keep_h  = hi_s[p] & ~lo_s[p] & ~kill & ~drop;
    assign start_h = hi_s[p] & ~lo_s[p] & ~kill & boot_ok[p] & ~blk_q;
    assign want_l  = lo_s[p] & ~hi_s[p] & ~kill;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_q <= 1'b0; l_q <= 1'b0; blk_q <= 1'b0; dc_q <= '0;
      end else begin
        if (!hi_s[p]) blk_q <= 1'b0;
        if (drop) blk_q <= 1'b1;
        if (h_q && !keep_h) begin
          h_q  <= 1'b0;
          dc_q <= DW'(DEAD_CYC);
        end else if (l_q && !want_l) begin
          l_q  <= 1'b0;
          dc_q <= DW'(DEAD_CYC);
        end else if (dc_q != '0) begin
          dc_q <= dc_q - 1'b1;
        end else if (start_h && !l_q) begin
          h_q <= 1'b1;
        end else if (want_l && !h_q) begin
          l_q <= 1'b1;
        end
      end
    end

    assign gh[p] = h_q;
    assign gl[p] = l_q;
  end

  assign asleep = (mode == M_SLEEP);
  assign hs_en  = {N_PH{~asleep}};
  assign ls_en  = {N_PH{~asleep}};
  assign hs_lvl = gh & {N_PH{run}};
  assign ls_lvl = gl & {N_PH{run}};
endmodule

// File: rtl/tri_gate_ctrl_chk.sv
module tri_gate_ctrl_chk #(
  parameter int N_PH     = 3,
  parameter int DEAD_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            coast_n,
  input logic [N_PH-1:0] boot_ok,
  input logic [N_PH-1:0] boot_low,
  input logic            disable_all,
  input logic            supply_good,
  input logic [N_PH-1:0] hs_en,
  input logic [N_PH-1:0] hs_lvl,
  input logic [N_PH-1:0] ls_en,
  input logic [N_PH-1:0] ls_lvl,
  input logic            fault_clr,
  input logic            asleep
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lvl & ls_lvl) == '0);  // R2
  AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!coast_n && !$past(coast_n) && !$past(coast_n, 2)) |=> (hs_lvl == '0 && ls_lvl == '0 && !fault_clr));  // R3
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    disable_all |=> (hs_lvl == '0 && ls_lvl == '0));  // R4
  AST_CLR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !fault_clr);  // R6
  AST_SLEEP_REL: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (hs_en == '0 && ls_en == '0 && hs_lvl == '0 && ls_lvl == '0));  // R7
  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> (hs_lvl == '0 && ls_lvl == '0));  // R10

  for (genvar p = 0; p < N_PH; p++) begin : g_chk
    int unsigned gap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap <= DEAD_CYC;
      else if (hs_lvl[p] || ls_lvl[p]) gap <= 0;
      else if (gap < DEAD_CYC) gap <= gap + 1;
    end
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_lvl[p]) || $rose(ls_lvl[p])) |-> gap >= DEAD_CYC);  // R2
    AST_BOOT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_lvl[p]) |-> $past(boot_ok[p]));  // R8
    AST_BOOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_lvl[p] && boot_low[p]) |=> !hs_lvl[p]);  // R9
  end
endmodule

bind tri_gate_ctrl tri_gate_ctrl_chk #(.N_PH(N_PH), .DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/tri_gate_ctrl_test.sv
module tri_gate_ctrl_test;
  localparam int CLK_NS = 10;

  typedef struct {
    int          due;
    logic [13:0] exp;
    string       tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, boot_ok = 3'b111, boot_low = '0;
  logic       coast_n = 1'b1, pin_rst_n = 1'b1, disable_all = 1'b0, supply_good = 1'b1;
  logic [2:0] hs_en, hs_lvl, ls_en, ls_lvl;
  logic       fault_clr, asleep;
  int         cyc = 0, checks = 0, errors = 0;
  item_t      q[$];
  item_t      it;
  logic [13:0] obs;

  tri_gate_ctrl uut (.*);

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign obs = {asleep, fault_clr, hs_en, hs_lvl, ls_en, ls_lvl};

  function automatic logic [13:0] vr(input logic [2:0] h, input logic [2:0] l, input logic fc);
    return {1'b0, fc, 3'b111, h, 3'b111, l};
  endfunction
  localparam logic [13:0] VSLEEP = 14'b10_000_000_000_000;

  task automatic expect_v(input int off, input logic [13:0] v, input string tag);
    item_t n;
    n.due = cyc + off; n.exp = v; n.tag = tag;
    q.push_back(n);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.due != cyc || obs !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.tag, obs, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_v(2, vr(3'b000, 3'b000, 0), "R11 reset state"); tick(3);
    // R1 high side on phase A with exact latency
    hi_cmd = 3'b001;
    expect_v(2, vr(3'b000, 3'b000, 0), "R1 not yet");
    expect_v(3, vr(3'b001, 3'b000, 0), "R1 high on"); tick(5);
    // R2 swap to low side: dead gap
    hi_cmd = 3'b000; lo_cmd = 3'b001;
    expect_v(3, vr(3'b000, 3'b000, 0), "R2 high off");
    expect_v(7, vr(3'b000, 3'b000, 0), "R2 gap end");
    expect_v(8, vr(3'b000, 3'b001, 0), "R2 low on"); tick(10);
    // R1 both commands on phase B
    hi_cmd = 3'b010; lo_cmd = 3'b011;
    expect_v(10, vr(3'b000, 3'b001, 0), "R1 both set off"); tick(10);
    hi_cmd = 3'b100; lo_cmd = 3'b011;
    expect_v(3, vr(3'b100, 3'b011, 0), "R1 mixed phases"); tick(6);
    // R3 coast
    coast_n = 1'b0;
    expect_v(3, vr(3'b000, 3'b000, 0), "R3 coast off");
    expect_v(6, vr(3'b000, 3'b000, 0), "R3 coast no clear"); tick(6);
    coast_n = 1'b1;
    expect_v(12, vr(3'b100, 3'b011, 0), "R3 coast release"); tick(12);
    // R4 disable all
    disable_all = 1'b1;
    expect_v(1, vr(3'b000, 3'b000, 0), "R4 disable immediate");
    expect_v(4, vr(3'b000, 3'b000, 0), "R4 disable held"); tick(4);
    disable_all = 1'b0;
    expect_v(10, vr(3'b100, 3'b011, 0), "R4 release"); tick(10);
    // R9 bootstrap dropout on phase C
    boot_low = 3'b100;
    expect_v(1, vr(3'b000, 3'b011, 0), "R9 dropout off"); tick(3);
    boot_low = 3'b000;
    expect_v(10, vr(3'b000, 3'b011, 0), "R9 stays off"); tick(10);
    hi_cmd = 3'b000; tick(3);
    hi_cmd = 3'b100;
    expect_v(3, vr(3'b100, 3'b011, 0), "R9 fresh edge on"); tick(5);
    // R8 bootstrap not ready on phase B
    boot_ok = 3'b101; hi_cmd = 3'b110; lo_cmd = 3'b001;
    expect_v(10, vr(3'b100, 3'b001, 0), "R8 blocked start"); tick(10);
    boot_ok = 3'b111;
    expect_v(1, vr(3'b110, 3'b001, 0), "R8 start when ready"); tick(4);
    // R5 short pulses
    pin_rst_n = 1'b0; tick(1); pin_rst_n = 1'b1;
    expect_v(3, vr(3'b110, 3'b001, 0), "R5 one cycle pulse");
    expect_v(4, vr(3'b110, 3'b001, 0), "R5 one cycle pulse after"); tick(6);
    pin_rst_n = 1'b0; tick(2); pin_rst_n = 1'b1;
    expect_v(3, vr(3'b110, 3'b001, 0), "R5 pulse below filter"); tick(6);
    // R6 clearing pulse at the filter boundary
    pin_rst_n = 1'b0; tick(3); pin_rst_n = 1'b1;
    expect_v(3, vr(3'b110, 3'b001, 1), "R6 clear strobe");
    expect_v(4, vr(3'b110, 3'b001, 0), "R6 strobe one cycle"); tick(6);
    pin_rst_n = 1'b0; tick(12); pin_rst_n = 1'b1;
    expect_v(3, vr(3'b110, 3'b001, 1), "R6 longer clear strobe"); tick(6);
    // R7 sleep entry
    pin_rst_n = 1'b0;
    expect_v(41, vr(3'b110, 3'b001, 0), "R7 before shutdown");
    expect_v(42, vr(3'b000, 3'b000, 1), "R7 shutdown drive low");
    expect_v(43, vr(3'b000, 3'b000, 0), "R7 hold-off");
    expect_v(61, vr(3'b000, 3'b000, 0), "R7 hold-off end");
    expect_v(62, VSLEEP, "R7 released"); tick(64);
    supply_good = 1'b0; tick(2);
    // R10 wake without supply
    pin_rst_n = 1'b1;
    expect_v(2, VSLEEP, "R10 still asleep");
    expect_v(3, vr(3'b000, 3'b000, 0), "R10 awake off");
    expect_v(10, vr(3'b000, 3'b000, 0), "R10 wait supply"); tick(10);
    supply_good = 1'b1;
    expect_v(1, vr(3'b110, 3'b001, 0), "R10 supply good"); tick(3);
    tick(2);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 pending actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule